// File: doc/BRIEF.md
# Stop-Mode Entry and Wakeup Sequencer

This block takes a small CPU core into a low-power stop state and brings it back. Software writes a control word whose stop bit requests entry. The same write selects the stop variant, the stabilization length and whether output ports float. After one entry dummy cycle the block holds the core, halts the peripheral timers and, if enabled, floats the ports. In the oscillator-halted variant it also drops the main oscillator enable.

Any bit of the wake request vector releases stop. In the oscillator-halted variant the block first waits for the oscillator-ready input. It then counts a selectable number of stabilization ticks. In the quick variant it leaves at once. One exit dummy cycle follows, in which the block tells the core whether to vector to the pending maskable interrupt or to continue inline at the next instruction. The resume decision depends on the master interrupt enable and on whether the core is inside a non-maskable or high-priority handler. Reset abandons the sequence and returns the block to normal running with no resume indication.

States: RUN (normal), ENTER (entry dummy), STOP (halted), OSC (waiting for oscillator ready), STAB (counting ticks), EXIT (exit dummy). Transitions: RUN→ENTER on a stop write; ENTER→STOP always; STOP→EXIT on a wake in quick mode, STOP→OSC on a wake otherwise; OSC→STAB on oscillator ready; STAB→EXIT when the count expires; EXIT→RUN always. Reset from any state leads to RUN.

Top module: `stop_wake_ctrl`

## Requirements
- R1: A write of the control word in RUN with bit 0 = 1 produces one cycle with dummy_cycle=1, core_hold=1, timer_halt=0 and stop_flag=1. From the following cycle, core_hold=1, timer_halt=1 and stop_flag=1.
- R2: While stopped, port_float equals control bit 3 as written at entry.
- R3: While stopped, osc_en equals control bit 4 (1 = quick variant, oscillator kept running; 0 = oscillator halted).
- R4: Any nonzero wake_req releases stop. A request already present when stop is written releases it immediately after the entry dummy cycle. Without a request the block stays stopped.
- R5: In the halted variant, after a wake the block waits for osc_ready, then counts 2^(STAB_BASE_LOG2 + 2*sel) stab_tick pulses, sel being control bits 2:1, before the exit dummy cycle.
- R6: In the quick variant, resume_valid rises on the cycle after the edge that samples the wake request.
- R7: resume_valid lasts exactly one cycle, with dummy_cycle=1, core_hold=1, timer_halt=0 and port_float=0. On the next cycle core_hold=0.
- R8: Outside any non-maskable or prioritized high-priority context, take_irq in the exit cycle equals mie.
- R9: With nmi_ctx=1, take_irq=0 (resume inline in the handler).
- R10: With prio_en=1 and hi_ctx=1, take_irq=0 and the request is left pending. With prio_en=0, hi_ctx has no effect.
- R11: Reset gives core_hold=0, timer_halt=0, port_float=0, osc_en=1, stop_flag=0, resume_valid=0. It releases a stopped core without any resume indication.
- R12: stop_flag clears at wakeup. A control write with bit 0 = 0 does not enter stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 5 | Control word: [0] stop, [2:1] stabilization select, [3] float enable, [4] quick |
| wake_req | input | N_SRC | Wake request sources (non-maskable, external, enabled) |
| osc_ready | input | 1 | Main oscillator has started |
| stab_tick | input | 1 | Free-running stabilization count enable |
| mie | input | 1 | Master interrupt enable |
| nmi_ctx | input | 1 | Core is inside a non-maskable handler |
| prio_en | input | 1 | Interrupt priority enabled |
| hi_ctx | input | 1 | Core is inside a high-priority handler |
| core_hold | output | 1 | Halt instruction execution |
| dummy_cycle | output | 1 | Entry or exit dummy cycle |
| timer_halt | output | 1 | Stop the peripheral timers |
| port_float | output | 1 | Drive output ports to high impedance |
| osc_en | output | 1 | Main oscillator enable |
| stop_flag | output | 1 | Stop bit of the control word |
| resume_valid | output | 1 | Exit cycle; resume decision valid |
| take_irq | output | 1 | 1 = vector to interrupt, 0 = next instruction |

## Verification
The bench varies when the oscillator becomes ready and when ticks start flowing, relative to the wake. A counter that ran before the oscillator was ready, or that counted idle cycles, would show a wrong exit cycle. Requests that are already present at the stop write check that entry cannot lose a wake that arrived early. Contexts are mixed randomly, so a decision that ignored the priority enable or let a non-maskable context vector would report the wrong take_irq. Reset in the middle of stop must never produce a resume pulse.

// File: rtl/swc_pkg.sv
package swc_pkg;
    localparam int CTL_W      = 5;
    localparam int BIT_STOP   = 0;
    localparam int BIT_SEL_LO = 1;
    localparam int BIT_FLT    = 3;
    localparam int BIT_QUICK  = 4;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_ENTER,
        ST_STOP,
        ST_OSC,
        ST_STAB,
        ST_EXIT
    } swc_state_e;

    typedef struct packed {
        logic       quick;
        logic       flt;
        logic [1:0] sel;
    } swc_cfg_t;
endpackage

// File: rtl/swc_ctl_reg.sv
module swc_ctl_reg
    import swc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CTL_W-1:0] wdata,
    input  logic             clr_stop,
    output swc_cfg_t         cfg,
    output logic             stop_bit
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg      <= '0;
            stop_bit <= 1'b0;
        end else begin
            if (wr_en) begin
                cfg.quick <= wdata[BIT_QUICK];
                cfg.flt   <= wdata[BIT_FLT];
                cfg.sel   <= wdata[BIT_SEL_LO +: 2];
            end
            if (wr_en && wdata[BIT_STOP])
                stop_bit <= 1'b1;
            else if (clr_stop)
                stop_bit <= 1'b0;
        end
    end
endmodule

// File: rtl/swc_stab_cnt.sv
module swc_stab_cnt #(
    parameter int BASE_LOG2 = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       tick,
    input  logic [1:0] sel,
    output logic       done
);
    localparam int CW = BASE_LOG2 + 7;

    logic [CW-1:0] cnt;
    logic [CW-1:0] last;

    always_comb begin
        last = (CW'(1) << (BASE_LOG2 + 2 * int'(sel))) - CW'(1);
        done = tick && (cnt == last);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (tick)
            cnt <= cnt + CW'(1);
    end
endmodule

// File: rtl/swc_resume.sv
module swc_resume (
    input  logic clk,
    input  logic rst_n,
    input  logic capture,
    input  logic mie,
    input  logic nmi_ctx,
    input  logic prio_en,
    input  logic hi_ctx,
    output logic take
);
    logic inline_ctx;

    always_comb inline_ctx = nmi_ctx || (prio_en && hi_ctx);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            take <= 1'b0;
        else if (capture)
            take <= mie && !inline_ctx;
    end
endmodule

// File: rtl/stop_wake_ctrl.sv
module stop_wake_ctrl
    import swc_pkg::*;
#(
    parameter int N_SRC          = 3,
    parameter int STAB_BASE_LOG2 = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic [CTL_W-1:0] ctl_wdata,
    input  logic [N_SRC-1:0] wake_req,
    input  logic             osc_ready,
    input  logic             stab_tick,
    input  logic             mie,
    input  logic             nmi_ctx,
    input  logic             prio_en,
    input  logic             hi_ctx,
    output logic             core_hold,
    output logic             dummy_cycle,
    output logic             timer_halt,
    output logic             port_float,
    output logic             osc_en,
    output logic             stop_flag,
    output logic             resume_valid,
    output logic             take_irq
);
    swc_state_e state, state_nx;
    swc_cfg_t   cfg;
    logic       wake_any, wr_en, stop_req, leave_stop, stab_done, take_q;

    always_comb begin
        wake_any   = |wake_req;
        wr_en      = ctl_wr && (state == ST_RUN);
        stop_req   = wr_en && ctl_wdata[BIT_STOP];
        leave_stop = (state == ST_STOP) && wake_any;
    end

    swc_ctl_reg u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wdata    (ctl_wdata),
        .clr_stop (leave_stop),
        .cfg      (cfg),
        .stop_bit (stop_flag)
    );

    swc_stab_cnt #(.BASE_LOG2(STAB_BASE_LOG2)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state != ST_STAB),
        .tick  ((state == ST_STAB) && stab_tick),
        .sel   (cfg.sel),
        .done  (stab_done)
    );

    swc_resume u_res (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (leave_stop),
        .mie     (mie),
        .nmi_ctx (nmi_ctx),
        .prio_en (prio_en),
        .hi_ctx  (hi_ctx),
        .take    (take_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_RUN;
        else
            state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN:   if (stop_req) state_nx = ST_ENTER;
            ST_ENTER: state_nx = ST_STOP;
            ST_STOP:  if (wake_any) state_nx = cfg.quick ? ST_EXIT : ST_OSC;
            ST_OSC:   if (osc_ready) state_nx = ST_STAB;
            ST_STAB:  if (stab_done) state_nx = ST_EXIT;
            ST_EXIT:  state_nx = ST_RUN;
            default:  state_nx = ST_RUN;
        endcase
    end

    always_comb begin
        core_hold    = 1'b1;
        dummy_cycle  = 1'b0;
        timer_halt   = 1'b1;
        port_float   = cfg.flt;
        osc_en       = 1'b1;
        resume_valid = 1'b0;
        take_irq     = 1'b0;
        unique case (state)
            ST_RUN: begin
                core_hold  = 1'b0;
                timer_halt = 1'b0;
                port_float = 1'b0;
            end
            ST_ENTER: begin
                dummy_cycle = 1'b1;
                timer_halt  = 1'b0;
                port_float  = 1'b0;
            end
            ST_STOP: osc_en = cfg.quick;
            ST_OSC:  ;
            ST_STAB: ;
            ST_EXIT: begin
                dummy_cycle  = 1'b1;
                timer_halt   = 1'b0;
                port_float   = 1'b0;
                resume_valid = 1'b1;
                take_irq     = take_q;
            end
            default: begin
                core_hold  = 1'b0;
                timer_halt = 1'b0;
                port_float = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/swc_checker.sv
module swc_checker (
    input logic clk,
    input logic rst_n,
    input logic core_hold,
    input logic dummy_cycle,
    input logic timer_halt,
    input logic port_float,
    input logic osc_en,
    input logic stop_flag,
    input logic resume_valid,
    input logic take_irq
);
    assert_entry_dummy_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timer_halt) |-> $past(dummy_cycle));

    assert_float_in_halt_R2: assert property (@(posedge clk) disable iff (!rst_n)
        port_float |-> timer_halt);

    assert_osc_off_halted_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |-> (timer_halt && core_hold));

    assert_exit_shape_R7: assert property (@(posedge clk) disable iff (!rst_n)
        resume_valid |-> (dummy_cycle && core_hold && !timer_halt && !port_float));

    assert_exit_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        resume_valid |=> (!core_hold && !resume_valid));

    assert_take_qualified_R8: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq |-> resume_valid);

    assert_flag_cleared_R12: assert property (@(posedge clk) disable iff (!rst_n)
        resume_valid |-> !stop_flag);
endmodule

bind stop_wake_ctrl swc_checker u_swc_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .core_hold    (core_hold),
    .dummy_cycle  (dummy_cycle),
    .timer_halt   (timer_halt),
    .port_float   (port_float),
    .osc_en       (osc_en),
    .stop_flag    (stop_flag),
    .resume_valid (resume_valid),
    .take_irq     (take_irq)
);

// File: tb/test_stop_wake_ctrl.sv
module test_stop_wake_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int N_SRC      = 3;
    localparam int BASE       = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ctl_wr = 1'b0;
    logic [4:0]       ctl_wdata = '0;
    logic [N_SRC-1:0] wake_req = '0;
    logic             osc_ready = 1'b1;
    logic             stab_tick = 1'b1;
    logic             mie = 1'b0, nmi_ctx = 1'b0, prio_en = 1'b0, hi_ctx = 1'b0;
    logic core_hold, dummy_cycle, timer_halt, port_float, osc_en, stop_flag, resume_valid, take_irq;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stop_wake_ctrl #(.N_SRC(N_SRC), .STAB_BASE_LOG2(BASE)) i_stop_wake_ctrl (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .wake_req(wake_req), .osc_ready(osc_ready), .stab_tick(stab_tick),
        .mie(mie), .nmi_ctx(nmi_ctx), .prio_en(prio_en), .hi_ctx(hi_ctx),
        .core_hold(core_hold), .dummy_cycle(dummy_cycle), .timer_halt(timer_halt),
        .port_float(port_float), .osc_en(osc_en), .stop_flag(stop_flag),
        .resume_valid(resume_valid), .take_irq(take_irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_take(input logic m, input logic n, input logic p, input logic h);
        return (m && !n && !(p && h)) ? 1 : 0;
    endfunction

    // m: osc_ready raised after counted edge m; j: ticks raised after counted edge j
    function automatic int exp_cycles(input logic quick, input int sel, input int m, input int j);
        int start;
        if (quick) return 1;
        start = (m + 2 > j + 1) ? m + 2 : j + 1;
        return start + (1 << (BASE + 2 * sel)) - 1;
    endfunction

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_stop(input logic flt, input logic quick, input int sel,
                           input logic m_ie, input logic n_c, input logic p_e, input logic h_c,
                           input logic [N_SRC-1:0] src, input logic prepend,
                           input int idle, input int m, input int j);
        int n;
        string dreq;
        mie = m_ie; nmi_ctx = n_c; prio_en = p_e; hi_ctx = h_c;
        if (prepend) wake_req = src;
        ctl_wr = 1'b1;
        ctl_wdata = {quick, flt, sel[1:0], 1'b1};
        step();
        ctl_wr = 1'b0;
        chk("R1 entry dummy", dummy_cycle, 1);
        chk("R1 entry hold", core_hold, 1);
        chk("R1 entry timers run", timer_halt, 0);
        chk("R1 stop flag set", stop_flag, 1);
        step();
        chk("R1 stopped hold", core_hold, 1);
        chk("R1 timers halted", timer_halt, 1);
        chk("R2 float", port_float, flt);
        chk("R3 osc enable", osc_en, quick);
        osc_ready = 1'b0;
        stab_tick = 1'b0;
        if (!prepend) begin
            for (int k = 0; k < idle; k++) begin
                step();
                chk("R4 no release without request", resume_valid, 0);
                chk("R4 still held", core_hold, 1);
            end
            wake_req = src;
        end
        n = 0;
        while (1) begin
            step();
            n++;
            if (n == m) osc_ready = 1'b1;
            if (n == j) stab_tick = 1'b1;
            if (resume_valid || n > 3000) break;
        end
        chk(quick ? "R6 quick exit cycle" : "R5 stabilization exit cycle",
            n, exp_cycles(quick, sel, m, j));
        if (n_c) dreq = "R9 nmi context";
        else if (p_e && h_c) dreq = "R10 high priority context";
        else dreq = "R8 mie decision";
        chk(dreq, take_irq, exp_take(m_ie, n_c, p_e, h_c));
        chk("R7 exit dummy", dummy_cycle, 1);
        chk("R7 timers resumed", timer_halt, 0);
        chk("R7 ports driven", port_float, 0);
        chk("R12 stop flag cleared", stop_flag, 0);
        wake_req = '0;
        step();
        chk("R7 core released", core_hold, 0);
        chk("R7 single exit cycle", resume_valid, 0);
        osc_ready = 1'b1;
        stab_tick = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk("R11 reset hold", core_hold, 0);
        chk("R11 reset osc", osc_en, 1);
        rst_n = 1'b1;
        step();
        chk("R11 reset flag", stop_flag, 0);
        chk("R11 reset timers", timer_halt, 0);
        chk("R11 reset float", port_float, 0);
        chk("R11 reset resume", resume_valid, 0);

        // R12: write without stop bit
        ctl_wr = 1'b1; ctl_wdata = 5'b11110;
        step();
        ctl_wr = 1'b0;
        chk("R12 no entry dummy", dummy_cycle, 0);
        step();
        chk("R12 no entry hold", core_hold, 0);

        // R4: each single source, quick
        for (int s = 0; s < N_SRC; s++)
            do_stop(1'b0, 1'b1, 0, 1'b1, 1'b0, 1'b0, 1'b0, N_SRC'(1) << s, 1'b0, 2, 1, 1);
        // R4 prepend, slow, ports floating
        do_stop(1'b1, 1'b0, 1, 1'b1, 1'b0, 1'b0, 1'b0, 3'b010, 1'b1, 0, 1, 1);
        // R5 late oscillator and late ticks
        do_stop(1'b0, 1'b0, 0, 1'b0, 1'b0, 1'b0, 1'b0, 3'b001, 1'b0, 1, 6, 1);
        do_stop(1'b1, 1'b0, 2, 1'b1, 1'b0, 1'b0, 1'b0, 3'b100, 1'b0, 1, 1, 12);
        do_stop(1'b0, 1'b0, 3, 1'b1, 1'b0, 1'b0, 1'b0, 3'b100, 1'b0, 0, 1, 1);
        // R9, R10 directed
        do_stop(1'b0, 1'b1, 0, 1'b1, 1'b1, 1'b0, 1'b0, 3'b001, 1'b0, 1, 1, 1);
        do_stop(1'b0, 1'b1, 0, 1'b1, 1'b0, 1'b1, 1'b1, 3'b010, 1'b0, 1, 1, 1);
        do_stop(1'b0, 1'b1, 0, 1'b1, 1'b0, 1'b0, 1'b1, 3'b010, 1'b0, 1, 1, 1);

        // R11: reset while stopped
        ctl_wr = 1'b1; ctl_wdata = 5'b00001;
        step();
        ctl_wr = 1'b0;
        step();
        rst_n = 1'b0;
        #1;
        chk("R11 reset releases hold", core_hold, 0);
        chk("R11 reset clears flag", stop_flag, 0);
        step();
        rst_n = 1'b1;
        wake_req = 3'b111;
        for (int k = 0; k < 5; k++) begin
            step();
            chk("R11 no resume after reset", resume_valid, 0);
        end
        wake_req = '0;

        // random mix
        for (int it = 0; it < 60; it++) begin
            logic [N_SRC-1:0] src;
            src = N_SRC'($urandom_range(1, (1 << N_SRC) - 1));
            do_stop(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                    int'($urandom_range(0, 3)),
                    1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) == 0),
                    1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                    src, 1'($urandom_range(0, 3) == 0),
                    int'($urandom_range(0, 3)), int'($urandom_range(1, 4)),
                    int'($urandom_range(1, 6)));
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule